// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that runs a fixed nine-instruction load/store set. Each instruction is fetched, decoded and executed in one clock. The set holds word load, word store, add, subtract, bitwise AND, bitwise OR, signed set-on-less-than, branch-on-equal and an absolute jump. The core contains the program counter with its next-address selection, a 32-entry register file, an ALU with its own operation decode, a main decoder, and two small word-addressed arrays: one for instructions and one for data.

A bench or a boot agent fills both arrays through a backdoor write port while reset is held. The core then runs from address 0. A debug port shows the current program counter and gives a combinational read of any register. Encodings: the opcode sits in bits 31:26. Register fields are rs in 25:21, rt in 20:16 and rd in 15:11. The shift-amount field is 10:6, the function code is 5:0 and the 16-bit immediate is 15:0. Opcode values are 0x00 for register-register operations, 0x23 for load, 0x2B for store, 0x04 for branch-on-equal and 0x02 for jump. Function codes are 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR and 0x2A set-on-less-than.

Top module: `sc_cpu_core`

## Requirements
- R1: When `rst` is high at a rising edge, the program counter becomes 0 and every register reads 0 afterwards. Stores are suppressed in that cycle.
- R2: Any instruction other than a branch or a jump sets the program counter to its own address plus 4 at the next edge.
- R3: Opcode 0x00 with shift field 0 and function 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs&rt or rs|rt into rd. Arithmetic wraps modulo 2^32.
- R4: Function 0x2A writes 1 into rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R5: Register 0 always reads as 0. Writes aimed at it have no effect.
- R6: A load (0x23) reads the data word at rs plus the sign-extended immediate. It writes that word into rt, not into rd.
- R7: A store (0x2B) writes rt to the data word at rs plus the sign-extended immediate. It leaves every register unchanged.
- R8: Branch-on-equal (0x04) moves the program counter to its address + 4 + (sign-extended immediate × 4) when rs equals rt. Otherwise it moves to its address + 4. Backward offsets are allowed.
- R9: A jump (0x02) sets the program counter to the upper 4 bits of (its address + 4), followed by instruction bits 25:0, followed by two zero bits.
- R10: An undefined opcode, an undefined function code, or a register-register operation with a non-zero shift field writes neither a register nor data memory. It only advances the program counter by 4.
- R11: A data access whose byte address is unaligned or lies beyond the data array returns 0 on a load. The same access is ignored on a store, with no wrap onto a lower word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_imem_we | input | 1 | Backdoor write strobe for the instruction array |
| ld_dmem_we | input | 1 | Backdoor write strobe for the data array |
| ld_addr | input | LD_AW | Backdoor word index |
| ld_data | input | 32 | Backdoor write word |
| dbg_reg_sel | input | 5 | Register selected for the debug read |
| dbg_pc | output | 32 | Current program counter |
| dbg_reg_val | output | 32 | Value of the selected register (combinational) |

## Verification
Every state element feeds the ports within one or two cycles. A wrong program counter shows on `dbg_pc` at the very next edge. It then fetches the wrong word, so later register values diverge as well. A corrupted register, a write to the wrong destination, or a stray write by a store shows on `dbg_reg_val` as soon as that register is selected after the offending edge. A bad data-array write becomes visible one instruction later, when a load brings the word back into a register.

// File: rtl/sc_cpu_pkg.sv
package sc_cpu_pkg;

   localparam int XLEN   = 32;
   localparam int REG_AW = 5;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_LW    = 6'h23;
   localparam logic [5:0] OP_SW    = 6'h2B;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_J     = 6'h02;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_SUB = 3'd1,
      ALU_AND = 3'd2,
      ALU_OR  = 3'd3,
      ALU_SLT = 3'd4
   } alu_op_e;

   typedef struct packed {
      logic    reg_dst;
      logic    alu_src;
      logic    mem_to_reg;
      logic    reg_write;
      logic    mem_write;
      logic    branch;
      logic    jump;
      alu_op_e alu_op;
   } ctrl_t;

endpackage

// File: rtl/sc_cpu_decode.sv
module sc_cpu_decode
   import sc_cpu_pkg::*;
(
   input  logic [5:0]  opcode,
   input  logic [4:0]  shamt,
   input  logic [5:0]  funct,
   output ctrl_t       ctrl
);

   logic    fn_ok;
   alu_op_e fn_op;

   // ALU operation decode for register-register instructions
   always_comb begin
      fn_ok = 1'b1;
      fn_op = ALU_ADD;
      case (funct)
         FN_ADD:  fn_op = ALU_ADD;
         FN_SUB:  fn_op = ALU_SUB;
         FN_AND:  fn_op = ALU_AND;
         FN_OR:   fn_op = ALU_OR;
         FN_SLT:  fn_op = ALU_SLT;
         default: fn_ok = 1'b0;
      endcase
      if (shamt != 5'd0) begin
         fn_ok = 1'b0;
      end
   end

   // main decode: anything unrecognised leaves every control low
   always_comb begin
      ctrl = '0;
      case (opcode)
         OP_RTYPE: begin
            if (fn_ok) begin
               ctrl.reg_dst   = 1'b1;
               ctrl.reg_write = 1'b1;
               ctrl.alu_op    = fn_op;
            end
         end
         OP_LW: begin
            ctrl.alu_src    = 1'b1;
            ctrl.mem_to_reg = 1'b1;
            ctrl.reg_write  = 1'b1;
            ctrl.alu_op     = ALU_ADD;
         end
         OP_SW: begin
            ctrl.alu_src   = 1'b1;
            ctrl.mem_write = 1'b1;
            ctrl.alu_op    = ALU_ADD;
         end
         OP_BEQ: begin
            ctrl.branch = 1'b1;
            ctrl.alu_op = ALU_SUB;
         end
         OP_J: begin
            ctrl.jump = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/sc_cpu_alu.sv
module sc_cpu_alu
   import sc_cpu_pkg::*;
#(
   parameter int W           = 32,
   parameter bit SLT_VIA_SUB = 1'b1
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y,
   output logic         zero
);

   if (W < 2) begin : g_bad_w
      $error("sc_cpu_alu: W must be at least 2");
   end

   logic [W-1:0] diff;
   logic         lt;

   assign diff = a - b;

   if (SLT_VIA_SUB) begin : g_slt_sub
      // reuse the subtractor: sign of difference corrected by overflow
      logic ovf;
      assign ovf = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);
      assign lt  = diff[W-1] ^ ovf;
   end else begin : g_slt_cmp
      assign lt = $signed(a) < $signed(b);
   end

   always_comb begin
      case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = diff;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(W-1){1'b0}}, lt};
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/sc_cpu_regfile.sv
module sc_cpu_regfile #(
   parameter int W     = 32,
   parameter int NREGS = 32,
   parameter int AW    = $clog2(NREGS)
)(
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   input  logic [AW-1:0] ra3,
   output logic [W-1:0]  rd1,
   output logic [W-1:0]  rd2,
   output logic [W-1:0]  rd3
);

   if (NREGS != (1 << AW)) begin : g_bad_n
      $error("sc_cpu_regfile: NREGS must equal 2**AW");
   end

   logic [W-1:0] regs [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      if (i == 0) begin : g_hardwired
         assign regs[i] = '0;
      end else begin : g_store
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst) begin
               q <= '0;
            end else if (we && (waddr == AW'(i))) begin
               q <= wdata;
            end
         end
         assign regs[i] = q;
      end
   end

   assign rd1 = regs[ra1];
   assign rd2 = regs[ra2];
   assign rd3 = regs[ra3];

endmodule

// File: rtl/sc_cpu_mem.sv
module sc_cpu_mem #(
   parameter int W     = 32,
   parameter int WORDS = 64,
   parameter int BDW   = $clog2(WORDS),
   parameter int IDXW  = $clog2(WORDS)
)(
   input  logic           clk,
   input  logic [31:0]    addr,
   input  logic           we,
   input  logic [W-1:0]   wdata,
   output logic [W-1:0]   rdata,
   input  logic           bd_we,
   input  logic [BDW-1:0] bd_addr,
   input  logic [W-1:0]   bd_data
);

   if (WORDS < 2 || WORDS != (1 << IDXW)) begin : g_bad_words
      $error("sc_cpu_mem: WORDS must be a power of two of at least 2");
   end
   if (BDW < IDXW || IDXW + 2 > 31) begin : g_bad_bdw
      $error("sc_cpu_mem: backdoor index too narrow or array too deep");
   end

   logic [W-1:0]    mem [WORDS];
   logic [IDXW-1:0] idx;
   logic [IDXW-1:0] bd_idx;
   logic            in_range;
   logic            bd_ok;

   assign idx      = addr[IDXW+1:2];
   assign in_range = (addr[31:IDXW+2] == '0) && (addr[1:0] == 2'b00);
   assign bd_idx   = bd_addr[IDXW-1:0];
   assign bd_ok    = (32'(bd_addr) < 32'(WORDS));

   always_ff @(posedge clk) begin
      if (bd_we && bd_ok) begin
         mem[bd_idx] <= bd_data;
      end else if (we && in_range) begin
         mem[idx] <= wdata;
      end
   end

   assign rdata = in_range ? mem[idx] : '0;

endmodule

// File: rtl/sc_cpu_core.sv
module sc_cpu_core
   import sc_cpu_pkg::*;
#(
   parameter int          IMEM_WORDS  = 64,
   parameter int          DMEM_WORDS  = 64,
   parameter int          NREGS       = 32,
   parameter bit          SLT_VIA_SUB = 1'b1,
   parameter logic [31:0] RESET_PC    = 32'h0000_0000,
   parameter int          LD_AW       = $clog2((IMEM_WORDS > DMEM_WORDS) ? IMEM_WORDS : DMEM_WORDS)
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_imem_we,
   input  logic             ld_dmem_we,
   input  logic [LD_AW-1:0] ld_addr,
   input  logic [31:0]      ld_data,
   input  logic [4:0]       dbg_reg_sel,
   output logic [31:0]      dbg_pc,
   output logic [31:0]      dbg_reg_val
);

   localparam int IDX_I = $clog2(IMEM_WORDS);
   localparam int IDX_D = $clog2(DMEM_WORDS);

   if (XLEN != 32) begin : g_bad_xlen
      $error("sc_cpu_core: field layout requires a 32-bit word");
   end
   if (NREGS != (1 << REG_AW)) begin : g_bad_nregs
      $error("sc_cpu_core: register count must match the 5-bit fields");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_pc
      $error("sc_cpu_core: RESET_PC must be word aligned");
   end
   if (LD_AW < IDX_I || LD_AW < IDX_D) begin : g_bad_ld
      $error("sc_cpu_core: LD_AW too narrow for the arrays");
   end

   logic [31:0] pc_q;
   logic [31:0] pc4;
   logic [31:0] pc_next;
   logic [31:0] br_tgt;
   logic [31:0] j_tgt;
   logic [31:0] instr;
   logic [31:0] imm_ext;
   logic [31:0] rs_val;
   logic [31:0] rt_val;
   logic [31:0] alu_b;
   logic [31:0] alu_y;
   logic [31:0] dm_rdata;
   logic [31:0] wb_data;
   logic [4:0]  wa;
   logic        alu_zero;
   logic        rf_we;
   logic        dm_we;
   ctrl_t       ctrl;

   // ---------------- fetch ----------------
   sc_cpu_mem #(
      .W     (32),
      .WORDS (IMEM_WORDS),
      .BDW   (LD_AW)
   ) u_imem (
      .clk     (clk),
      .addr    (pc_q),
      .we      (1'b0),
      .wdata   (32'h0),
      .rdata   (instr),
      .bd_we   (ld_imem_we),
      .bd_addr (ld_addr),
      .bd_data (ld_data)
   );

   // ---------------- decode ----------------
   sc_cpu_decode u_dec (
      .opcode (instr[31:26]),
      .shamt  (instr[10:6]),
      .funct  (instr[5:0]),
      .ctrl   (ctrl)
   );

   assign imm_ext = {{16{instr[15]}}, instr[15:0]};
   assign wa      = ctrl.reg_dst ? instr[15:11] : instr[20:16];
   assign rf_we   = ctrl.reg_write;

   sc_cpu_regfile #(
      .W     (32),
      .NREGS (NREGS)
   ) u_rf (
      .clk   (clk),
      .rst   (rst),
      .we    (rf_we),
      .waddr (wa),
      .wdata (wb_data),
      .ra1   (instr[25:21]),
      .ra2   (instr[20:16]),
      .ra3   (dbg_reg_sel),
      .rd1   (rs_val),
      .rd2   (rt_val),
      .rd3   (dbg_reg_val)
   );

   // ---------------- execute ----------------
   assign alu_b = ctrl.alu_src ? imm_ext : rt_val;

   sc_cpu_alu #(
      .W           (32),
      .SLT_VIA_SUB (SLT_VIA_SUB)
   ) u_alu (
      .a    (rs_val),
      .b    (alu_b),
      .op   (ctrl.alu_op),
      .y    (alu_y),
      .zero (alu_zero)
   );

   // ---------------- memory ----------------
   assign dm_we = ctrl.mem_write && !rst;

   sc_cpu_mem #(
      .W     (32),
      .WORDS (DMEM_WORDS),
      .BDW   (LD_AW)
   ) u_dmem (
      .clk     (clk),
      .addr    (alu_y),
      .we      (dm_we),
      .wdata   (rt_val),
      .rdata   (dm_rdata),
      .bd_we   (ld_dmem_we),
      .bd_addr (ld_addr),
      .bd_data (ld_data)
   );

   assign wb_data = ctrl.mem_to_reg ? dm_rdata : alu_y;

   // ---------------- next address ----------------
   assign pc4    = pc_q + 32'd4;
   assign br_tgt = pc4 + {imm_ext[29:0], 2'b00};
   assign j_tgt  = {pc4[31:28], instr[25:0], 2'b00};

   always_comb begin
      if (ctrl.jump) begin
         pc_next = j_tgt;
      end else if (ctrl.branch && alu_zero) begin
         pc_next = br_tgt;
      end else begin
         pc_next = pc4;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= RESET_PC;
      end else begin
         pc_q <= pc_next;
      end
   end

   assign dbg_pc = pc_q;

endmodule

// File: rtl/sc_cpu_checker.sv
module sc_cpu_checker
   import sc_cpu_pkg::*;
(
   input logic        clk,
   input logic        rst,
   input logic [31:0] pc,
   input logic [31:0] instr,
   input logic        rf_we,
   input logic        dm_we,
   input logic [4:0]  dbg_reg_sel,
   input logic [31:0] dbg_reg_val
);

   logic [5:0]  op;
   logic [31:0] seq_pc;
   logic [31:0] jump_pc;
   logic        is_flow;
   logic        is_known;
   logic        rst_q;

   assign op       = instr[31:26];
   assign seq_pc   = pc + 32'd4;
   assign jump_pc  = {seq_pc[31:28], instr[25:0], 2'b00};
   assign is_flow  = (op == OP_BEQ) || (op == OP_J);
   assign is_known = (op == OP_RTYPE) || (op == OP_LW) || (op == OP_SW) || is_flow;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst_q == 1'b1) begin
         a_r1_pc_after_reset: assert (pc == 32'h0)
            else $error("R1: pc not zero after reset");
      end
   end

   a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
      !is_flow |=> (pc == $past(seq_pc)));

   a_r5_zero_reg: assert property (@(posedge clk) disable iff (rst)
      (dbg_reg_sel == 5'd0) |-> (dbg_reg_val == 32'h0));

   a_r7_store_no_rf: assert property (@(posedge clk) disable iff (rst)
      (op == OP_SW) |-> !rf_we);

   a_r9_jump_target: assert property (@(posedge clk) disable iff (rst)
      (op == OP_J) |=> (pc == $past(jump_pc)));

   a_r10_undef_quiet: assert property (@(posedge clk) disable iff (rst)
      !is_known |-> (!rf_we && !dm_we));

endmodule

bind sc_cpu_core sc_cpu_checker u_chk (
   .clk         (clk),
   .rst         (rst),
   .pc          (dbg_pc),
   .instr       (instr),
   .rf_we       (rf_we),
   .dm_we       (dm_we),
   .dbg_reg_sel (dbg_reg_sel),
   .dbg_reg_val (dbg_reg_val)
);

// File: tb/sc_cpu_core_test.sv
module sc_cpu_core_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ld_imem_we = 1'b0;
   logic        ld_dmem_we = 1'b0;
   logic [5:0]  ld_addr = '0;
   logic [31:0] ld_data = '0;
   logic [4:0]  dbg_reg_sel = '0;
   logic [31:0] dbg_pc;
   logic [31:0] dbg_reg_val;

   int checks   = 0;
   int failures = 0;

   always #4 clk = ~clk;

   sc_cpu_core uut (
      .clk         (clk),
      .rst         (rst),
      .ld_imem_we  (ld_imem_we),
      .ld_dmem_we  (ld_dmem_we),
      .ld_addr     (ld_addr),
      .ld_data     (ld_data),
      .dbg_reg_sel (dbg_reg_sel),
      .dbg_pc      (dbg_pc),
      .dbg_reg_val (dbg_reg_val)
   );

   // {funct, a, b, expected}
   localparam logic [101:0] VEC [10] = '{
      {6'h20, 32'd5,         32'd7,         32'd12},
      {6'h20, 32'hFFFF_FFFF, 32'd1,         32'd0},
      {6'h22, 32'd10,        32'd3,         32'd7},
      {6'h22, 32'd3,         32'd10,        32'hFFFF_FFF9},
      {6'h24, 32'hF0F0_FF00, 32'h0FF0_F0F0, 32'h00F0_F000},
      {6'h25, 32'hF0F0_FF00, 32'h0FF0_F0F0, 32'hFFF0_FFF0},
      {6'h2A, 32'hFFFF_FFFF, 32'd1,         32'd1},
      {6'h2A, 32'd1,         32'hFFFF_FFFF, 32'd0},
      {6'h2A, 32'd5,         32'd5,         32'd0},
      {6'h2A, 32'h8000_0000, 32'h7FFF_FFFF, 32'd1}
   };

   function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] s,
                                         input logic [4:0] t, input logic [4:0] d,
                                         input logic [4:0] sh);
      return {6'h00, s, t, d, sh, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] s,
                                         input logic [4:0] t, input logic [15:0] imm);
      return {op, s, t, imm};
   endfunction

   function automatic logic [31:0] enc_j(input logic [25:0] tgt);
      return {6'h02, tgt};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic iput(input int idx, input logic [31:0] w);
      ld_addr    = 6'(idx);
      ld_data    = w;
      ld_imem_we = 1'b1;
      @(negedge clk);
      ld_imem_we = 1'b0;
   endtask

   task automatic dput(input int idx, input logic [31:0] w);
      ld_addr    = 6'(idx);
      ld_data    = w;
      ld_dmem_we = 1'b1;
      @(negedge clk);
      ld_dmem_we = 1'b0;
   endtask

   task automatic start_prog();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 16; i++) iput(i, 32'h0);
   endtask

   task automatic run(input int n);
      rst = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic rreg(input logic [4:0] sel, output logic [31:0] v);
      dbg_reg_sel = sel;
      #1;
      v = dbg_reg_val;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] v;

      // ---- table of register-register operations: R3, R4, R2, R6 ----
      for (int k = 0; k < 10; k++) begin
         start_prog();
         iput(0, enc_i(6'h23, 5'd0, 5'd1, 16'd0));
         iput(1, enc_i(6'h23, 5'd0, 5'd2, 16'd4));
         iput(2, enc_r(VEC[k][101:96], 5'd1, 5'd2, 5'd3, 5'd0));
         dput(0, VEC[k][95:64]);
         dput(1, VEC[k][63:32]);
         run(3);
         rreg(5'd3, v);
         chk((VEC[k][101:96] == 6'h2A) ? "R4 slt" : "R3 alu", v, VEC[k][31:0]);
         if (k == 0) begin
            chk("R2 pc after three steps", dbg_pc, 32'd12);
            rreg(5'd1, v);
            chk("R6 load into rt", v, 32'd5);
         end
      end

      // ---- R1: reset clears pc and registers ----
      rst = 1'b1;
      @(negedge clk);
      chk("R1 pc reset", dbg_pc, 32'd0);
      rreg(5'd3, v);
      chk("R1 reg3 reset", v, 32'd0);
      rreg(5'd1, v);
      chk("R1 reg1 reset", v, 32'd0);

      // ---- R5: register 0 ----
      start_prog();
      iput(0, enc_i(6'h23, 5'd0, 5'd1, 16'd0));
      iput(1, enc_r(6'h20, 5'd1, 5'd1, 5'd0, 5'd0));
      iput(2, enc_i(6'h23, 5'd0, 5'd0, 16'd0));
      dput(0, 32'h0000_1234);
      run(3);
      rreg(5'd0, v);
      chk("R5 reg0 stays zero", v, 32'd0);
      rreg(5'd1, v);
      chk("R6 load value", v, 32'h0000_1234);

      // ---- R7 / R6: store with negative offset ----
      start_prog();
      iput(0, enc_i(6'h23, 5'd0, 5'd1, 16'd0));
      iput(1, enc_i(6'h23, 5'd0, 5'd4, 16'd4));
      iput(2, enc_i(6'h2B, 5'd4, 5'd1, 16'hFFFC));
      iput(3, enc_i(6'h23, 5'd0, 5'd5, 16'd4));
      dput(0, 32'hCAFE_0001);
      dput(1, 32'd8);
      run(4);
      rreg(5'd5, v);
      chk("R7 stored word read back", v, 32'hCAFE_0001);
      rreg(5'd1, v);
      chk("R7 store leaves rt register", v, 32'hCAFE_0001);
      rreg(5'd4, v);
      chk("R7 store leaves base register", v, 32'd8);

      // ---- R8: branches ----
      start_prog();
      iput(0, enc_i(6'h23, 5'd0, 5'd1, 16'd0));
      iput(1, enc_i(6'h23, 5'd0, 5'd2, 16'd4));
      iput(2, enc_i(6'h04, 5'd1, 5'd2, 16'd2));
      iput(3, enc_i(6'h23, 5'd0, 5'd3, 16'd0));
      iput(4, enc_i(6'h23, 5'd0, 5'd3, 16'd0));
      iput(5, enc_i(6'h04, 5'd1, 5'd0, 16'd5));
      iput(6, enc_i(6'h04, 5'd0, 5'd0, 16'hFFF9));
      dput(0, 32'd9);
      dput(1, 32'd9);
      run(3);
      chk("R8 taken forward", dbg_pc, 32'd20);
      rreg(5'd3, v);
      chk("R8 skipped loads", v, 32'd0);
      run(1);
      chk("R8 not taken", dbg_pc, 32'd24);
      run(1);
      chk("R8 taken backward", dbg_pc, 32'd0);

      // ---- R9: jumps ----
      start_prog();
      iput(0, enc_j(26'd5));
      iput(5, enc_j(26'd2));
      run(1);
      chk("R9 jump forward", dbg_pc, 32'd20);
      run(1);
      chk("R9 jump backward", dbg_pc, 32'd8);

      // ---- R10: undefined encodings ----
      start_prog();
      iput(0, enc_i(6'h23, 5'd0, 5'd1, 16'd0));
      iput(1, enc_i(6'h3F, 5'd0, 5'd1, 16'd4));
      iput(2, enc_r(6'h20, 5'd1, 5'd1, 5'd2, 5'd3));
      iput(3, enc_r(6'h3F, 5'd1, 5'd1, 5'd3, 5'd0));
      dput(0, 32'h55);
      run(4);
      chk("R10 pc advances", dbg_pc, 32'd16);
      rreg(5'd1, v);
      chk("R10 bad opcode no write", v, 32'h55);
      rreg(5'd2, v);
      chk("R10 nonzero shamt no write", v, 32'd0);
      rreg(5'd3, v);
      chk("R10 bad funct no write", v, 32'd0);

      // ---- R11: out-of-range data access ----
      start_prog();
      iput(0, enc_i(6'h23, 5'd0, 5'd1, 16'd0));
      iput(1, enc_i(6'h2B, 5'd0, 5'd1, 16'h0104));
      iput(2, enc_i(6'h23, 5'd0, 5'd2, 16'd4));
      iput(3, enc_i(6'h23, 5'd0, 5'd1, 16'h0100));
      dput(0, 32'h77);
      dput(1, 32'h11);
      run(4);
      rreg(5'd2, v);
      chk("R11 store beyond array ignored", v, 32'h11);
      rreg(5'd1, v);
      chk("R11 load beyond array gives zero", v, 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule